// File: doc/BRIEF.md
# Grouped Twelve-Channel PWM Generator

This block drives twelve output pins from already-resolved setpoints. The pins form three banks of four consecutive channels. Each bank owns one frequency setpoint, and every channel has its own duty code in tenths of a percent. A per-channel mode bit chooses what drives the pin: the modulator, or a plain static level taken from a separate general-output bit.

A tick input paces all period counters. Each bank turns its frequency into a period length in ticks, using the tick rate given as a parameter. It then holds each channel high for the matching share of that period. New setpoints are latched at the next period boundary of their bank, so a change never produces a cut-short pulse. A frequency of zero parks the bank's modulated pins low.

Top module: `pwm12_bank`

## Requirements
- R1: Pins 0–3 run at the period of frequency word 0, pins 4–7 at word 1, and pins 8–11 at word 2. Word g occupies bits [16g+15:16g] of `freq_words`.
- R2: Bit i of `pwm_enable` governs pin i for i = 0..11. Bits 12–15 have no effect on any pin.
- R3: When bit i of `pwm_enable` is 0, pin i equals the value that `gp_out[i]` had one clock earlier.
- R4: A modulated pin with a high time strictly between 0 and the period repeats every P ticks, where P = floor(TICK_HZ / frequency).
- R5: Within each period, a modulated pin is high for floor(min(duty,1000) × P / 1000) ticks. Channel c's duty code occupies bits [16c+15:16c] of `duty_words`.
- R6: A duty code of 0 holds the pin constantly low. A code of 1000 or more holds it constantly high, with no pulse at period edges.
- R7: When P is 0 (frequency 0 or above TICK_HZ), every modulated pin of that bank stays low.
- R8: A bank latches its period and duty values only at its period boundary. Between boundaries the latched values do not change.
- R9: While the synchronous reset `rst` is high, all pins are low and all latched periods and duties are cleared.
- R10: Period counters advance only on cycles where `tick` is high. With a tick on every n-th clock, one period spans n × P clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Time-base strobe that advances the period counters |
| freq_words | input | 48 | Three 16-bit bank frequencies, in pulses per second |
| duty_words | input | 192 | Twelve 16-bit duty codes, 0..1000 |
| pwm_enable | input | 16 | Per-channel mode bit: 1 selects the modulator, 0 the static level |
| gp_out | input | 12 | Static level for each channel in static mode |
| pins | output | 12 | Registered output pins |

## Verification
Static-mode pins are registered, so they show a change of `gp_out` or `pwm_enable` one clock later. The bench samples them at the falling edge after the next rising edge. A modulated setpoint only takes hold at the next boundary of its bank, which can be as much as one old period away, and then needs one more clock to reach the pin register. The bench therefore waits well over two of the longest periods after any change before it looks. It then counts high samples and rising edges over a window that is a whole multiple of every period in use. Because of this, the result does not depend on where the window starts relative to the counters' phase.

// File: rtl/pwm12_pkg.sv
package pwm12_pkg;

  // Period length in ticks for a requested frequency; 0 means the bank is idle.
  function automatic logic [31:0] period_ticks(input logic [31:0] tick_hz,
                                               input logic [31:0] freq);
    if (freq == 32'd0) return 32'd0;
    return tick_hz / freq;
  endfunction

  // High time in ticks: duty clamped to full scale, scaled by the period.
  function automatic logic [31:0] high_ticks(input logic [31:0] duty,
                                             input logic [31:0] period,
                                             input logic [31:0] full);
    logic [31:0] d;
    d = (duty > full) ? full : duty;
    return (d * period) / full;
  endfunction

endpackage

// File: rtl/pwm_group.sv
module pwm_group #(
  parameter int CH        = 4,
  parameter int FREQ_W    = 16,
  parameter int DUTY_W    = 16,
  parameter int TICK_HZ   = 1_000_000,
  parameter int DUTY_FULL = 1000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic [FREQ_W-1:0]    freq,
  input  logic [CH*DUTY_W-1:0] duty_flat,
  output logic [CH-1:0]        pwm_raw
);
  import pwm12_pkg::*;

  localparam int PER_W = $clog2(TICK_HZ + 1);

  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] plen;
  logic [PER_W-1:0] hlen     [CH];
  logic [PER_W-1:0] new_per;
  logic [PER_W-1:0] new_high [CH];
  logic             last_tick;
  logic             period_start;

  assign new_per      = PER_W'(period_ticks(32'(TICK_HZ), 32'(freq)));
  assign last_tick    = (plen == '0) || (cnt == plen - PER_W'(1));
  assign period_start = tick && last_tick;

  always_comb begin
    for (int k = 0; k < CH; k++) begin
      new_high[k] = PER_W'(high_ticks(32'(duty_flat[k*DUTY_W +: DUTY_W]),
                                      32'(new_per), 32'(DUTY_FULL)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      plen <= '0;
      for (int k = 0; k < CH; k++) hlen[k] <= '0;
    end else if (period_start) begin
      cnt  <= '0;
      plen <= new_per;
      for (int k = 0; k < CH; k++) hlen[k] <= new_high[k];
    end else if (tick) begin
      cnt <= cnt + PER_W'(1);
    end
  end

  generate
    for (genvar k = 0; k < CH; k++) begin : g_ch
      assign pwm_raw[k] = (cnt < hlen[k]);

      // R6: a latched high time never exceeds the latched period
      assert_high_within_period_R6: assert property (@(posedge clk) disable iff (rst)
        hlen[k] <= plen);

      // R8: duty is only re-latched at a period boundary
      assert_duty_held_midperiod_R8: assert property (@(posedge clk) disable iff (rst)
        !period_start |=> $stable(hlen[k]));
    end
  endgenerate

  // R4: the counter stays inside the active period
  assert_count_in_period_R4: assert property (@(posedge clk) disable iff (rst)
    (plen != '0) |-> (cnt < plen));

  // R10: without a tick the counter holds
  assert_count_needs_tick_R10: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

endmodule

// File: rtl/pwm_pin_stage.sv
module pwm_pin_stage #(
  parameter int CH = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] mode_pwm,
  input  logic [CH-1:0] level,
  input  logic [CH-1:0] pwm_raw,
  output logic [CH-1:0] pin
);

  always_ff @(posedge clk) begin
    if (rst) pin <= '0;
    else     pin <= (mode_pwm & pwm_raw) | (~mode_pwm & level);
  end

  // R3: static-mode pins follow the level one clock later
  assert_static_follow_R3: assert property (@(posedge clk) disable iff (rst)
    (~mode_pwm != '0) |=> (((pin ^ $past(level)) & ~$past(mode_pwm)) == '0));

endmodule

// File: rtl/pwm12_bank.sv
module pwm12_bank #(
  parameter int GROUPS       = 3,
  parameter int CH_PER_GROUP = 4,
  parameter int FREQ_W       = 16,
  parameter int DUTY_W       = 16,
  parameter int EN_W         = 16,
  parameter int TICK_HZ      = 1_000_000,
  parameter int DUTY_FULL    = 1000
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       tick,
  input  logic [GROUPS*FREQ_W-1:0]                   freq_words,
  input  logic [GROUPS*CH_PER_GROUP*DUTY_W-1:0]      duty_words,
  input  logic [EN_W-1:0]                            pwm_enable,
  input  logic [GROUPS*CH_PER_GROUP-1:0]             gp_out,
  output logic [GROUPS*CH_PER_GROUP-1:0]             pins
);

  localparam int CH = GROUPS * CH_PER_GROUP;

  logic [CH-1:0] pwm_raw;
  logic [CH-1:0] mode_pwm;

  assign mode_pwm = pwm_enable[CH-1:0];

  generate
    if (EN_W > CH) begin : g_spare_en
      logic unused_en_hi;
      assign unused_en_hi = ^pwm_enable[EN_W-1:CH];
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_bank
      pwm_group #(
        .CH       (CH_PER_GROUP),
        .FREQ_W   (FREQ_W),
        .DUTY_W   (DUTY_W),
        .TICK_HZ  (TICK_HZ),
        .DUTY_FULL(DUTY_FULL)
      ) u_grp (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .freq     (freq_words[g*FREQ_W +: FREQ_W]),
        .duty_flat(duty_words[g*CH_PER_GROUP*DUTY_W +: CH_PER_GROUP*DUTY_W]),
        .pwm_raw  (pwm_raw[g*CH_PER_GROUP +: CH_PER_GROUP])
      );
    end
  endgenerate

  pwm_pin_stage #(.CH(CH)) u_pins (
    .clk     (clk),
    .rst     (rst),
    .mode_pwm(mode_pwm),
    .level   (gp_out),
    .pwm_raw (pwm_raw),
    .pin     (pins)
  );

endmodule

// File: tb/pwm12_bank_test.sv
module pwm12_bank_test;
  localparam int TICK = 12000;
  localparam int G    = 3;
  localparam int CPG  = 4;
  localparam int CH   = G * CPG;
  localparam int FW   = 16;
  localparam int DW   = 16;
  localparam int EW   = 16;
  localparam int FULL = 1000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst  = 1'b1;
  logic              tick = 1'b0;
  logic [G*FW-1:0]   freq = '0;
  logic [CH*DW-1:0]  duty = '0;
  logic [EW-1:0]     en   = '0;
  logic [CH-1:0]     gpo  = '0;
  wire  [CH-1:0]     pins;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;

  typedef struct {int ch; int highs; int rises; string tag;} item_t;
  item_t sbq[$];

  pwm12_bank #(.TICK_HZ(TICK)) uut (
    .clk(clk), .rst(rst), .tick(tick), .freq_words(freq),
    .duty_words(duty), .pwm_enable(en), .gp_out(gpo), .pins(pins)
  );

  initial begin : tick_gen
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      if (ph + 1 >= tick_div) begin tick = 1'b1; ph = 0; end
      else begin tick = 1'b0; ph++; end
    end
  end

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_period(int f);
    return (f == 0) ? 0 : TICK / f;
  endfunction

  function automatic int exp_high(int d, int p);
    return ((d > FULL) ? FULL : d) * p / FULL;
  endfunction

  task automatic set_freq(int g, int f);
    freq[g*FW +: FW] = FW'(f);
  endtask

  task automatic set_duty(int c, int d);
    duty[c*DW +: DW] = DW'(d);
  endtask

  task automatic wait_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver side of the scoreboard: expected counts for a window of W clocks.
  task automatic push_expect(int W, string extra);
    for (int c = 0; c < CH; c++) begin
      item_t it;
      int p, h, cp;
      p  = exp_period(int'(freq[(c/CPG)*FW +: FW]));
      h  = exp_high(int'(duty[c*DW +: DW]), p);
      cp = p * tick_div;
      it.ch = c;
      if (!en[c]) begin
        it.highs = gpo[c] ? W : 0; it.rises = 0; it.tag = {extra, "R3"};
      end else if (p == 0) begin
        it.highs = 0; it.rises = 0; it.tag = {extra, "R7"};
      end else begin
        it.highs = (W / cp) * h * tick_div;
        it.rises = (h == 0 || h == p) ? 0 : W / cp;
        if (tick_div > 1)             it.tag = {extra, "R10"};
        else if (h == 0 || h == p)    it.tag = {extra, "R6"};
        else                          it.tag = {extra, "R5"};
      end
      sbq.push_back(it);
    end
  endtask

  // Monitor side: count highs and rising edges, then pop and compare.
  task automatic run_window(int W);
    int hi [CH];
    int ri [CH];
    logic [CH-1:0] prev;
    for (int c = 0; c < CH; c++) begin hi[c] = 0; ri[c] = 0; end
    @(negedge clk);
    prev = pins;
    for (int n = 0; n < W; n++) begin
      @(negedge clk);
      for (int c = 0; c < CH; c++) begin
        if (pins[c]) hi[c]++;
        if (pins[c] && !prev[c]) ri[c]++;
      end
      prev = pins;
    end
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check(it.tag, hi[it.ch], it.highs, $sformatf("pin %0d high count", it.ch));
      check("R1/R4", ri[it.ch], it.rises, $sformatf("pin %0d pulse count", it.ch));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    // R9: reset holds all pins low even with everything enabled
    en = 16'h0FFF; gpo = 12'hFFF;
    set_freq(0, 1000); set_freq(1, 1000); set_freq(2, 1000);
    for (int c = 0; c < CH; c++) set_duty(c, 500);
    wait_cycles(6);
    check("R9", int'(pins), 0, "pins during reset");

    // R3: static mode, pin follows level one clock later
    en = '0; gpo = 12'hA5C; rst = 1'b0;
    @(negedge clk);
    check("R3", int'(pins), 'hA5C, "static level");
    gpo = 12'h3A1;
    @(negedge clk);
    check("R3", int'(pins), 'h3A1, "static level change");

    // R2: bits 12..15 of the enable word are ignored
    en = 16'hF000; gpo = 12'h2C3;
    @(negedge clk);
    check("R2", int'(pins), 'h2C3, "upper enable bits ignored");

    // Scenario A: three distinct bank rates, assorted duties
    set_freq(0, 100); set_freq(1, 400); set_freq(2, 1000);
    set_duty(0, 500);  set_duty(1, 250); set_duty(2, 1000); set_duty(3, 0);
    set_duty(4, 700);  set_duty(5, 1);   set_duty(6, 999);  set_duty(7, 333);
    set_duty(8, 500);  set_duty(9, 100); set_duty(10, 0);   set_duty(11, 1200);
    en = 16'h0FFF;
    wait_cycles(600);
    push_expect(720, "");
    run_window(720);

    // Scenario B: bank 1 idle, bank 0 duties changed mid-run (R8, R7)
    set_freq(1, 0);
    set_duty(0, 100); set_duty(1, 900); set_duty(2, 1); set_duty(3, 9);
    wait_cycles(600);
    push_expect(720, "R8 ");
    run_window(720);

    // Scenario C: tick every second clock, bank 1 in static mode (R10, R3)
    tick_div = 2;
    en  = 16'h0F0F;
    gpo = 12'h0F0;
    wait_cycles(800);
    push_expect(720, "");
    run_window(720);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule